// File: doc/BRIEF.md
# Self-Describing Link Packet Framer

This block turns a variable-length run of 32-bit payload words from a single data path into a packet that describes itself on a point-to-point link. A packet opens with one header word and closes with one trailer word. The header identifies where the data came from: a format version, a data-source code, a region identifier, a bunch counter and a level-2 buffer number. The trailer reports how many payload words actually went out and carries a set of error flags.

A producer asks for a packet by raising a start request with the header fields. The request may also mark the packet as empty. The producer then streams payload words over a valid/ready interface and tags the final word with a last marker. Payload words pass straight through to the output stream with no added latency. The framer slots the header in before them and the trailer after them, and it holds off any new start request until the trailer has been taken. Serialisation and line signalling belong to the stages downstream of this block.

Top module: `link_framer`

## Requirements
- R1: Each packet leaves as exactly one header word, then every accepted payload word in arrival order and unmodified, then exactly one trailer word.
- R2: The header word is packed as follows: version in bits [31:24], source code in [23:20], region in [19:18], bunch counter in [9:2] and buffer number in [1:0]. Bits [17:10] are zero. The source codes in use are 0 (global), 1 (muon), 2 (silicon tracker) and 3 (cluster), and any 4-bit value passes through unchanged.
- R3: The header fields are captured in the cycle the start request is accepted. Later changes on the header inputs do not change the header word of that packet.
- R4: The trailer word holds the payload word count in bits [31:16] and the error flags in bits [15:0]. The count excludes the header and the trailer.
- R5: The error flags are taken from `err_in` in the cycle the payload word marked last is accepted. Values on `err_in` in every other cycle of a non-empty packet have no effect.
- R6: When more than 65535 payload words are accepted, the count stays at 0xFFFF and the block forces error-flag bit 0 to one. The next packet starts again from a count of zero with bit 0 clear.
- R7: The output follows valid/ready rules. While `out_valid` is high and `out_ready` is low, the word is held stable. A payload word is accepted (`pl_ready`) only in a cycle in which it is forwarded and taken downstream.
- R8: `start_ready` stays low from the cycle after a start is accepted until the trailer of that packet has been accepted.
- R9: A start request with `start_empty` high produces a header followed directly by a trailer with count zero. Its error flags are taken from `err_in` when that start is accepted.
- R10: During reset and right after it, `out_valid` and `pl_ready` are low and `start_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Packet start request |
| start_ready | output | 1 | Framer is idle and can accept a start |
| start_empty | input | 1 | Requested packet carries no payload |
| hdr_ver | input | 8 | Format version for the header |
| hdr_src | input | 4 | Data-source code for the header |
| hdr_region | input | 2 | Region identifier for the header |
| hdr_bx | input | 8 | Bunch counter for the header |
| hdr_buf | input | 2 | Level-2 buffer number for the header |
| pl_valid | input | 1 | Payload word valid |
| pl_ready | output | 1 | Payload word accepted this cycle |
| pl_data | input | 32 | Payload word |
| pl_last | input | 1 | Marks the final payload word |
| err_in | input | 16 | Error flags, sampled with the last payload word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Header, payload or trailer word |

## Verification
Several properties are checked on every cycle: output words hold still under back-pressure, `start_ready` drops after a start, the captured header stays frozen while a packet is open, an empty packet moves straight to a zero-count trailer, and the count saturates and raises its overflow flag only at the limit. The bench's scenarios are what show the exact bit packing of header and trailer, the payload order, and that `err_in` is taken only with the last word. They also show that junk on the header inputs after a start has no effect, and that a count past 65535 saturates and then clears for the next packet. These scenarios use stalls on the input side and the output side, and every word is compared with values built from the requirements.

// File: rtl/lf_pkg.sv
package lf_pkg;
    localparam int WORD_W  = 32;
    localparam int VER_W   = 8;
    localparam int SRC_W   = 4;
    localparam int REG_W   = 2;
    localparam int BX_W    = 8;
    localparam int BUF_W   = 2;
    localparam int VER_LSB = 24;
    localparam int SRC_LSB = 20;
    localparam int REG_LSB = 18;
    localparam int BX_LSB  = 2;
    localparam int BUF_LSB = 0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_TRL
    } lf_state_e;

    typedef struct packed {
        logic [VER_W-1:0] ver;
        logic [SRC_W-1:0] src;
        logic [REG_W-1:0] region;
        logic [BX_W-1:0]  bx;
        logic [BUF_W-1:0] bufn;
    } lf_hdr_t;
endpackage

// File: rtl/lf_hdr_pack.sv
module lf_hdr_pack
    import lf_pkg::*;
(
    input  lf_hdr_t             fields,
    output logic [WORD_W-1:0]   word
);
    always_comb begin
        word = '0;
        word[VER_LSB +: VER_W] = fields.ver;
        word[SRC_LSB +: SRC_W] = fields.src;
        word[REG_LSB +: REG_W] = fields.region;
        word[BX_LSB  +: BX_W]  = fields.bx;
        word[BUF_LSB +: BUF_W] = fields.bufn;
    end
endmodule

// File: rtl/lf_pay_counter.sv
module lf_pay_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d.cnt = '0;
            c_d.ovf = 1'b0;
        end else if (inc) begin
            if (c_q.cnt == CNT_MAX) begin
                c_d.ovf = 1'b1;
            end else begin
                c_d.cnt = c_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt = c_q.cnt;
    assign ovf = c_q.ovf;

    // R6: once at the limit the count stays there until cleared
    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.cnt == CNT_MAX && !clr) |=> (c_q.cnt == CNT_MAX));

    // R6: overflow flag only rises when the count was already full
    assert_ovf_at_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_q.ovf && inc && !clr && c_q.cnt != CNT_MAX) |=> !c_q.ovf);
endmodule

// File: rtl/link_framer.sv
module link_framer
    import lf_pkg::*;
#(
    parameter  int SIZE_W = 16,
    localparam int FLAG_W = WORD_W - SIZE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic              start_empty,
    input  logic [VER_W-1:0]  hdr_ver,
    input  logic [SRC_W-1:0]  hdr_src,
    input  logic [REG_W-1:0]  hdr_region,
    input  logic [BX_W-1:0]   hdr_bx,
    input  logic [BUF_W-1:0]  hdr_buf,
    input  logic              pl_valid,
    output logic              pl_ready,
    input  logic [WORD_W-1:0] pl_data,
    input  logic              pl_last,
    input  logic [FLAG_W-1:0] err_in,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    typedef struct packed {
        lf_state_e         st;
        lf_hdr_t           hdr;
        logic              empty;
        logic [FLAG_W-1:0] err;
    } ctl_t;

    ctl_t r_d, r_q;

    logic              start_fire;
    logic              pl_fire;
    logic [WORD_W-1:0] hdr_word;
    logic [SIZE_W-1:0] pay_cnt;
    logic              pay_ovf;
    lf_hdr_t           hdr_in;

    assign hdr_in = '{ver: hdr_ver, src: hdr_src, region: hdr_region,
                      bx: hdr_bx, bufn: hdr_buf};

    lf_hdr_pack u_hdr (
        .fields (r_q.hdr),
        .word   (hdr_word)
    );

    lf_pay_counter #(.CNT_W(SIZE_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_fire),
        .inc   (pl_fire),
        .cnt   (pay_cnt),
        .ovf   (pay_ovf)
    );

    // handshake and output mux
    always_comb begin
        start_ready = (r_q.st == ST_IDLE);
        start_fire  = start_valid && start_ready;
        pl_ready    = (r_q.st == ST_PAY) && out_ready;
        pl_fire     = pl_valid && pl_ready;
        case (r_q.st)
            ST_HDR: begin
                out_valid = 1'b1;
                out_data  = hdr_word;
            end
            ST_PAY: begin
                out_valid = pl_valid;
                out_data  = pl_data;
            end
            ST_TRL: begin
                out_valid = 1'b1;
                out_data  = {pay_cnt, r_q.err | FLAG_W'(pay_ovf)};
            end
            default: begin
                out_valid = 1'b0;
                out_data  = '0;
            end
        endcase
    end

    // next-state computation
    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start_fire) begin
                    r_d.hdr   = hdr_in;
                    r_d.empty = start_empty;
                    r_d.err   = start_empty ? err_in : '0;
                    r_d.st    = ST_HDR;
                end
            end
            ST_HDR: begin
                if (out_ready) begin
                    r_d.st = r_q.empty ? ST_TRL : ST_PAY;
                end
            end
            ST_PAY: begin
                if (pl_fire && pl_last) begin
                    r_d.err = err_in;
                    r_d.st  = ST_TRL;
                end
            end
            ST_TRL: begin
                if (out_ready) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, hdr: '0, empty: 1'b0, err: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // R7: a stalled output word stays put
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8: no second start until the trailer is taken
    assert_start_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_fire |=> !start_ready);

    // R3: captured header does not move while a packet is open
    assert_hdr_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> $stable(r_q.hdr));

    // R9: empty packet goes from header straight to a zero-size trailer
    assert_empty_trl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HDR && r_q.empty && out_ready)
            |=> (out_valid && out_data[WORD_W-1 -: SIZE_W] == '0));
endmodule

// File: tb/tb_link_framer.sv
`timescale 1ns/1ps
module tb_link_framer;
    typedef struct packed {
        logic        empty;
        logic [17:0] len;
        logic [7:0]  ver;
        logic [3:0]  src;
        logic [1:0]  region;
        logic [7:0]  bx;
        logic [1:0]  bufn;
        logic [15:0] err;
        logic [1:0]  mode;   // bit0: input gaps, bit1: output stalls
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 18'd1,  8'h01, 4'd0, 2'd0, 8'h00, 2'd0, 16'h0000, 2'd0},
        '{1'b0, 18'd5,  8'hA5, 4'd1, 2'd3, 8'hFF, 2'd3, 16'h8000, 2'd1},
        '{1'b0, 18'd8,  8'h3C, 4'd2, 2'd1, 8'h5A, 2'd2, 16'h1234, 2'd2},
        '{1'b0, 18'd12, 8'hFF, 4'd3, 2'd2, 8'h81, 2'd1, 16'hFFFE, 2'd3},
        '{1'b1, 18'd0,  8'h02, 4'd1, 2'd1, 8'h10, 2'd1, 16'h00F0, 2'd2},
        '{1'b0, 18'd3,  8'h11, 4'hF, 2'd0, 8'h7E, 2'd0, 16'h0001, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0, start_ready, start_empty = 1'b0;
    logic [7:0]  hdr_ver = '0;
    logic [3:0]  hdr_src = '0;
    logic [1:0]  hdr_region = '0;
    logic [7:0]  hdr_bx = '0;
    logic [1:0]  hdr_buf = '0;
    logic        pl_valid = 1'b0, pl_ready, pl_last = 1'b0;
    logic [31:0] pl_data = '0;
    logic [15:0] err_in = '0;
    logic        out_valid, out_ready = 1'b0;
    logic [31:0] out_data;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    link_framer dut (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_ready(start_ready), .start_empty(start_empty),
        .hdr_ver(hdr_ver), .hdr_src(hdr_src), .hdr_region(hdr_region),
        .hdr_bx(hdr_bx), .hdr_buf(hdr_buf),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data), .pl_last(pl_last),
        .err_in(err_in),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pay_word(input int i, input logic [7:0] s);
        return (32'(i) * 32'h9E3779B1) ^ {24'h0, s};
    endfunction

    task automatic run_pkt(input vec_t v);
        int          len_i = int'(v.len);
        int          total = v.empty ? 2 : len_i + 2;
        int          cyc = 0, idx = 0, k = 0;
        bit          started = 0, pend = 0, block_bad = 0;
        bit          hbad = 0, pbad = 0, tbad = 0;
        logic [31:0] hexp, texp, exp_w;
        logic [31:0] ha = '0, pa = '0, pe = '0, ta = '0;
        logic [15:0] sz, fl;
        hexp = {v.ver, v.src, v.region, 8'h00, v.bx, v.bufn};
        sz   = (len_i > 65535) ? 16'hFFFF : 16'(len_i);
        fl   = v.err | ((len_i > 65535) ? 16'h0001 : 16'h0000);
        texp = {sz, fl};
        while (k < total && cyc < 180000) begin
            @(negedge clk);
            start_valid = !started;
            start_empty = v.empty;
            // R3: junk on header inputs once started
            hdr_ver    = started ? ~v.ver    : v.ver;
            hdr_src    = started ? ~v.src    : v.src;
            hdr_region = started ? ~v.region : v.region;
            hdr_bx     = started ? ~v.bx     : v.bx;
            hdr_buf    = started ? ~v.bufn   : v.bufn;
            pl_valid   = started && (idx < len_i) && (pend || !v.mode[0] || (cyc % 3 != 1));
            pl_data    = pay_word(idx, v.ver);
            pl_last    = (idx == len_i - 1);
            if (v.empty)
                err_in = started ? (16'h5A5A ^ 16'(cyc)) : v.err;
            else
                err_in = (pl_valid && pl_last) ? v.err : (16'hA5A5 ^ 16'(cyc));
            out_ready  = v.mode[1] ? (cyc % 3 != 0) : 1'b1;
            #1;
            if (started && start_ready) block_bad = 1;
            if (start_valid && start_ready) started = 1;
            pend = pl_valid && !pl_ready;
            if (pl_valid && pl_ready) idx++;
            if (out_valid && out_ready) begin
                if (k == 0) begin
                    if (out_data !== hexp) begin hbad = 1; ha = out_data; end
                end else if (k == total - 1) begin
                    if (out_data !== texp) begin tbad = 1; ta = out_data; end
                end else begin
                    exp_w = pay_word(k - 1, v.ver);
                    if (out_data !== exp_w && !pbad) begin
                        pbad = 1; pa = out_data; pe = exp_w;
                    end
                end
                k++;
            end
            cyc++;
        end
        @(negedge clk);
        start_valid = 1'b0;
        pl_valid    = 1'b0;
        check(k == total, "R1 word count", 32'(k), 32'(total));
        check(!hbad, "R2 R3 header", ha, hexp);
        if (!v.empty)
            check(!pbad, "R1 R7 payload", pa, pe);
        if (v.empty)
            check(!tbad, "R9 empty trailer", ta, texp);
        else if (len_i > 65535)
            check(!tbad, "R6 saturated trailer", ta, texp);
        else
            check(!tbad, "R4 R5 trailer", ta, texp);
        check(!block_bad, "R8 start blocked", 32'(block_bad), 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid && start_ready && !pl_ready, "R10 in reset",
              {29'd0, out_valid, start_ready, pl_ready}, 32'h2);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!out_valid && start_ready && !pl_ready, "R10 after reset",
              {29'd0, out_valid, start_ready, pl_ready}, 32'h2);

        for (int i = 0; i < NVEC; i++) begin
            run_pkt(VECS[i]);
        end

        // R6: more than 65535 payload words saturates and sets flag bit 0
        run_pkt('{1'b0, 18'h10000, 8'h42, 4'd3, 2'd1, 8'h33, 2'd2, 16'h0040, 2'd0});
        // R6: following packet starts from zero again with bit 0 clear
        run_pkt('{1'b0, 18'd2, 8'h43, 4'd0, 2'd2, 8'h34, 2'd3, 16'h0100, 2'd1});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule